// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the configuration front end of a legacy multi-function I/O controller. A host reaches three byte-wide configuration registers through a pair of byte addresses. The even address holds a pointer that selects a register, and the odd address moves data to or from the selected register. The three registers are function enable, function address and power/test. Reads of the pointer address first return a fixed identification byte. After that they return the pointer itself.

At reset the pointer clears and the three registers load from built-in tables indexed by a five-bit strap input. The block decodes the register contents into registered enables, I/O base addresses and interrupt numbers. These cover a parallel port, two UARTs, a floppy controller and an IDE controller. The decoded outputs feed the address decoders of those functions, which lie outside this block.

Two further features apply to data writes. Each accepted data write raises a one-cycle reconfigure pulse when the new decode appears. A lock bit in the power/test register blocks all further data writes until reset.

The identification logic is a two-state machine:
- `ID_ARMED` is entered at reset. A pointer read in this state returns 0x88.
- `ID_SPENT` is reached from `ID_ARMED` by the transition `ARM_TO_SPENT_READ` (a pointer read) or by `ARM_TO_SPENT_WRITE` (a pointer write).
- `ID_SPENT` keeps its state through the transition `SPENT_HOLD` until the next reset.

Top module: `sio_cfg_port`

## Requirements
- R1: A write with `port_sel`=0 stores `wdata` as the pointer. Once `ID_SPENT` is reached, a read with `port_sel`=0 returns the pointer.
- R2: After reset, the first read with `port_sel`=0 returns 0x88. Every later pointer read returns the pointer value.
- R3: A pointer write made before any pointer read ends the identification byte. The next pointer read returns the written pointer, not 0x88.
- R4: A data write (`port_sel`=1) with pointer 0, 1 or 2 updates the enable, address or power/test register respectively, and a data read returns it.
- R5: A data write with a pointer of 3 or more changes nothing and gives no reconfigure pulse. A data read with such a pointer returns 0.
- R6: Reset clears the pointer and loads the three registers from the strap tables. For example, strap 1 gives enable 0x4F and address 0x11, strap 3 gives address 0x39, and strap 31 gives enable 0x00 and power/test 0x02.
- R7: The enable register bits are decoded as follows:
  - bit 0 enables the parallel port;
  - bits 1 and 2 enable UART 0 and UART 1;
  - bit 3 enables the floppy controller, and bit 5 moves its base from 0x3F0 to 0x370; its IRQ is 6;
  - bit 6 enables IDE, and bit 7 moves its base from 0x1F0 to 0x170; its IRQ is 14 and its alternate base is the IDE base plus 0x206.
- R8: Address bits 1:0 select the parallel base 0x378, 0x3BC, 0x278 or 0 (codes 0 to 3). The parallel IRQ depends on the same code:
  - code 0 gives 7 when power/test bit 3 is set and 5 otherwise;
  - code 1 gives 7, code 2 gives 5 and code 3 gives 0.
- R9: UART u takes a code from address bits 2u+3:2u+2 and a selector from address bits 7:6. The base is chosen by the code:
  - code 0 gives 0x3F8 and code 1 gives 0x2F8;
  - code 2 gives {0x3E8,0x338,0x2E8,0x220}[selector];
  - code 3 gives {0x2E8,0x238,0x2E0,0x228}[selector].
  The IRQ is 3 for odd codes and 4 for even codes.
- R10: Take the clock edge that samples an accepted data write. The read-back value changes at that edge. The decoded outputs change at the following edge, and `reconfig` is high for exactly the one cycle after that edge.
- R11: While power/test bit 6 is set, data writes change no register and give no pulse. A reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 5 | Strap value selecting the reset contents |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| port_sel | input | 1 | Address bit 0: 0 selects the pointer, 1 selects data |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while `rd_stb` is high, 0 otherwise |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 10 | Parallel port base address |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | UART enables, bit u for UART u |
| uart_base | output | 2x10 | UART base addresses |
| uart_irq | output | 2x4 | UART IRQs |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 10 | Floppy controller base address |
| fdc_irq | output | 4 | Floppy controller IRQ |
| ide_en | output | 1 | IDE enable |
| ide_base | output | 10 | IDE base address |
| ide_alt_base | output | 10 | IDE alternate status base address |
| ide_irq | output | 4 | IDE IRQ |
| reconfig | output | 1 | One-cycle pulse when new decoded values appear |

## Verification
The bench tests the identification byte in two ways: two reads in a row, and a pointer write before any read. A design that let the byte survive a pointer write, or showed it twice, would return 0x88 where the pointer is expected. It writes through out-of-range pointers and while the lock bit is set, then reads the registers back. A design that aliased pointer 3 and above onto a register, or ignored the lock, would show a changed read-back value or a spurious reconfigure pulse. It steps every parallel code and all four UART codes with several selectors, and checks the pulse and decode timing. A design with the tables swapped, the odd/even IRQ rule inverted, or a pulse one cycle early or late would give wrong bases or IRQs, or show `reconfig` in the wrong cycle.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
    localparam int BASE_W    = 10;
    localparam int IRQ_W     = 4;
    localparam int NUM_UART  = 2;
    localparam int STRAP_W   = 5;
    localparam int NUM_STRAP = 1 << STRAP_W;
    localparam int NUM_REG   = 3;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t ena;
        byte_t adr;
        byte_t pwr;
    } cfg_regs_t;

    // enable register bit positions
    localparam int ENA_PAR     = 0;
    localparam int ENA_UART0   = 1;
    localparam int ENA_FDC     = 3;
    localparam int ENA_FDC_ALT = 5;
    localparam int ENA_IDE     = 6;
    localparam int ENA_IDE_ALT = 7;
    // power/test register bit positions
    localparam int PWR_PAR_IRQ7 = 3;
    localparam int PWR_LOCK     = 6;

    localparam byte_t ID_BYTE = 8'h88;

    localparam logic [BASE_W-1:0] IDE_ALT_OFS = BASE_W'('h206);
    localparam logic [IRQ_W-1:0]  FDC_IRQ_NUM = IRQ_W'(6);
    localparam logic [IRQ_W-1:0]  IDE_IRQ_NUM = IRQ_W'(14);

    localparam byte_t ENA_TAB [NUM_STRAP] = '{
        8'h4f, 8'h4f, 8'h4f, 8'h4f, 8'h4f, 8'h4f, 8'h4b, 8'h4b,
        8'h4b, 8'h4b, 8'h4b, 8'h4b, 8'h0f, 8'h0f, 8'h0f, 8'h0f,
        8'h49, 8'h49, 8'h49, 8'h49, 8'h07, 8'h07, 8'h07, 8'h07,
        8'h47, 8'h47, 8'h47, 8'h47, 8'h47, 8'h47, 8'h08, 8'h00};
    localparam byte_t ADR_TAB [NUM_STRAP] = '{
        8'h10, 8'h11, 8'h11, 8'h39, 8'h24, 8'h38, 8'h00, 8'h01,
        8'h01, 8'h09, 8'h08, 8'h08, 8'h10, 8'h11, 8'h39, 8'h24,
        8'h00, 8'h01, 8'h01, 8'h00, 8'h10, 8'h11, 8'h39, 8'h24,
        8'h10, 8'h11, 8'h11, 8'h39, 8'h24, 8'h38, 8'h10, 8'h10};

    localparam logic [BASE_W-1:0] PAR_BASE_TAB [4] = '{
        BASE_W'('h378), BASE_W'('h3BC), BASE_W'('h278), BASE_W'('h000)};
    localparam logic [BASE_W-1:0] UART_ALT_EVEN [4] = '{
        BASE_W'('h3E8), BASE_W'('h338), BASE_W'('h2E8), BASE_W'('h220)};
    localparam logic [BASE_W-1:0] UART_ALT_ODD [4] = '{
        BASE_W'('h2E8), BASE_W'('h238), BASE_W'('h2E0), BASE_W'('h228)};

    function automatic cfg_regs_t strap_defaults(logic [STRAP_W-1:0] s);
        cfg_regs_t r;
        r.ena = ENA_TAB[s];
        r.adr = ADR_TAB[s];
        r.pwr = (s == STRAP_W'(NUM_STRAP - 1)) ? 8'h02 : 8'h00;
        return r;
    endfunction

    function automatic logic [BASE_W-1:0] uart_base_of(logic [1:0] code, logic [1:0] sel);
        case (code)
            2'd0:    return BASE_W'('h3F8);
            2'd1:    return BASE_W'('h2F8);
            2'd2:    return UART_ALT_EVEN[sel];
            default: return UART_ALT_ODD[sel];
        endcase
    endfunction
endpackage

// File: rtl/sio_cfg_idfsm.sv
`timescale 1ns/1ps
module sio_cfg_idfsm (
    input  logic clk,
    input  logic rst_n,
    input  logic idx_rd,
    input  logic idx_wr,
    output logic show_id
);
    typedef enum logic {ID_ARMED, ID_SPENT} id_state_e;

    id_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ID_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ID_ARMED: if (idx_rd || idx_wr) state_d = ID_SPENT; // ARM_TO_SPENT_READ / _WRITE
            ID_SPENT: state_d = ID_SPENT;                       // SPENT_HOLD
        endcase
    end

    always_comb show_id = (state_q == ID_ARMED);
endmodule

// File: rtl/sio_cfg_regs.sv
`timescale 1ns/1ps
module sio_cfg_regs
    import sio_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic               port_sel,
    input  logic [7:0]         wdata,
    input  logic               show_id,
    output logic [7:0]         rdata,
    output cfg_regs_t          regs_q,
    output logic [7:0]         index_q,
    output logic               accept_q
);
    logic idx_wr, dat_wr, idx_valid, locked, accept;

    assign idx_wr    = wr_stb && !port_sel;
    assign dat_wr    = wr_stb && port_sel;
    assign idx_valid = (index_q < 8'(NUM_REG));
    assign locked    = regs_q.pwr[PWR_LOCK];
    assign accept    = dat_wr && idx_valid && !locked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q  <= 8'h00;
            regs_q   <= strap_defaults(strap);
            accept_q <= 1'b0;
        end else begin
            accept_q <= accept;
            if (idx_wr) index_q <= wdata;
            if (accept) begin
                case (index_q[1:0])
                    2'd0:    regs_q.ena <= wdata;
                    2'd1:    regs_q.adr <= wdata;
                    2'd2:    regs_q.pwr <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_stb) begin
            if (!port_sel) begin
                rdata = show_id ? ID_BYTE : index_q;
            end else if (idx_valid) begin
                case (index_q[1:0])
                    2'd0:    rdata = regs_q.ena;
                    2'd1:    rdata = regs_q.adr;
                    default: rdata = regs_q.pwr;
                endcase
            end
        end
    end
endmodule

// File: rtl/sio_cfg_decode.sv
`timescale 1ns/1ps
module sio_cfg_decode
    import sio_cfg_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  cfg_regs_t                          regs,
    input  logic                               accept_q,
    output logic                               par_en,
    output logic [BASE_W-1:0]                  par_base,
    output logic [IRQ_W-1:0]                   par_irq,
    output logic [NUM_UART-1:0]                uart_en,
    output logic [NUM_UART-1:0][BASE_W-1:0]    uart_base,
    output logic [NUM_UART-1:0][IRQ_W-1:0]     uart_irq,
    output logic                               fdc_en,
    output logic [BASE_W-1:0]                  fdc_base,
    output logic                               ide_en,
    output logic [BASE_W-1:0]                  ide_base,
    output logic [BASE_W-1:0]                  ide_alt_base,
    output logic                               reconfig
);
    logic [NUM_UART-1:0][BASE_W-1:0] ubase_d;
    logic [NUM_UART-1:0][IRQ_W-1:0]  uirq_d;
    logic [IRQ_W-1:0]                pirq_d;
    logic [BASE_W-1:0]               ide_base_d;
    logic                            unused_bits;

    assign unused_bits = ^{regs.ena[4], regs.pwr[7:4], regs.pwr[2:0]};

    for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
        logic [1:0] code;
        assign code       = regs.adr[2*u+2 +: 2];
        assign ubase_d[u] = uart_base_of(code, regs.adr[7:6]);
        assign uirq_d[u]  = code[0] ? IRQ_W'(3) : IRQ_W'(4);
    end

    always_comb begin
        case (regs.adr[1:0])
            2'd0:    pirq_d = regs.pwr[PWR_PAR_IRQ7] ? IRQ_W'(7) : IRQ_W'(5);
            2'd1:    pirq_d = IRQ_W'(7);
            2'd2:    pirq_d = IRQ_W'(5);
            default: pirq_d = IRQ_W'(0);
        endcase
    end

    assign ide_base_d = regs.ena[ENA_IDE_ALT] ? BASE_W'('h170) : BASE_W'('h1F0);

    always_ff @(posedge clk) begin
        par_en       <= regs.ena[ENA_PAR];
        par_base     <= PAR_BASE_TAB[regs.adr[1:0]];
        par_irq      <= pirq_d;
        uart_en      <= regs.ena[ENA_UART0 +: NUM_UART];
        uart_base    <= ubase_d;
        uart_irq     <= uirq_d;
        fdc_en       <= regs.ena[ENA_FDC];
        fdc_base     <= regs.ena[ENA_FDC_ALT] ? BASE_W'('h370) : BASE_W'('h3F0);
        ide_en       <= regs.ena[ENA_IDE];
        ide_base     <= ide_base_d;
        ide_alt_base <= ide_base_d + IDE_ALT_OFS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reconfig <= 1'b0;
        else        reconfig <= accept_q;
    end
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
    import sio_cfg_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [STRAP_W-1:0]              strap,
    input  logic                            rd_stb,
    input  logic                            wr_stb,
    input  logic                            port_sel,
    input  logic [7:0]                      wdata,
    output logic [7:0]                      rdata,
    output logic                            par_en,
    output logic [BASE_W-1:0]               par_base,
    output logic [IRQ_W-1:0]                par_irq,
    output logic [NUM_UART-1:0]             uart_en,
    output logic [NUM_UART-1:0][BASE_W-1:0] uart_base,
    output logic [NUM_UART-1:0][IRQ_W-1:0]  uart_irq,
    output logic                            fdc_en,
    output logic [BASE_W-1:0]               fdc_base,
    output logic [IRQ_W-1:0]                fdc_irq,
    output logic                            ide_en,
    output logic [BASE_W-1:0]               ide_base,
    output logic [BASE_W-1:0]               ide_alt_base,
    output logic [IRQ_W-1:0]                ide_irq,
    output logic                            reconfig
);
    logic      show_id;
    logic      accept_q;
    cfg_regs_t regs_q;
    logic [7:0] index_q;

    sio_cfg_idfsm u_idfsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_rd  (rd_stb && !port_sel),
        .idx_wr  (wr_stb && !port_sel),
        .show_id (show_id)
    );

    sio_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (strap),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .port_sel (port_sel),
        .wdata    (wdata),
        .show_id  (show_id),
        .rdata    (rdata),
        .regs_q   (regs_q),
        .index_q  (index_q),
        .accept_q (accept_q)
    );

    sio_cfg_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .regs         (regs_q),
        .accept_q     (accept_q),
        .par_en       (par_en),
        .par_base     (par_base),
        .par_irq      (par_irq),
        .uart_en      (uart_en),
        .uart_base    (uart_base),
        .uart_irq     (uart_irq),
        .fdc_en       (fdc_en),
        .fdc_base     (fdc_base),
        .ide_en       (ide_en),
        .ide_base     (ide_base),
        .ide_alt_base (ide_alt_base),
        .reconfig     (reconfig)
    );

    assign fdc_irq = FDC_IRQ_NUM;
    assign ide_irq = IDE_IRQ_NUM;
endmodule

// File: rtl/sio_cfg_chk.sv
`timescale 1ns/1ps
module sio_cfg_chk
    import sio_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic       port_sel,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       show_id,
    input logic [7:0] index_q,
    input cfg_regs_t  regs_q,
    input logic       accept_q,
    input logic       reconfig
);
    assert_index_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !port_sel) |=> (index_q == $past(wdata)));

    assert_id_spent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !port_sel) |=> !show_id);

    assert_id_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !show_id |=> !show_id);

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && port_sel && index_q == 8'd1 && !regs_q.pwr[PWR_LOCK])
        |=> (regs_q.adr == $past(wdata)));

    assert_bad_index_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && port_sel && index_q > 8'd2) |-> (rdata == 8'h00));

    assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |-> $past(accept_q));

    assert_lock_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && regs_q.pwr[PWR_LOCK]) |=> $stable(regs_q));
endmodule

bind sio_cfg_port sio_cfg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .port_sel (port_sel),
    .wdata    (wdata),
    .rdata    (rdata),
    .show_id  (show_id),
    .index_q  (index_q),
    .regs_q   (regs_q),
    .accept_q (accept_q),
    .reconfig (reconfig)
);

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;
    import sio_cfg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [STRAP_W-1:0] strap = 5'd1;
    logic rd_stb = 1'b0, wr_stb = 1'b0, port_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic par_en, fdc_en, ide_en, reconfig;
    logic [BASE_W-1:0] par_base, fdc_base, ide_base, ide_alt_base;
    logic [IRQ_W-1:0] par_irq, fdc_irq, ide_irq;
    logic [NUM_UART-1:0] uart_en;
    logic [NUM_UART-1:0][BASE_W-1:0] uart_base;
    logic [NUM_UART-1:0][IRQ_W-1:0] uart_irq;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #2.5 clk = ~clk;

    sio_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .strap(strap), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .port_sel(port_sel), .wdata(wdata), .rdata(rdata), .par_en(par_en),
        .par_base(par_base), .par_irq(par_irq), .uart_en(uart_en),
        .uart_base(uart_base), .uart_irq(uart_irq), .fdc_en(fdc_en),
        .fdc_base(fdc_base), .fdc_irq(fdc_irq), .ide_en(ide_en),
        .ide_base(ide_base), .ide_alt_base(ide_alt_base), .ide_irq(ide_irq),
        .reconfig(reconfig)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read bytes and compares them mid-cycle
    always @(negedge clk) begin
        if (rd_stb) begin
            if (sb_q.size() == 0) begin
                chk("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk(it.tag, {24'h0, rdata}, {24'h0, it.exp});
            end
        end
    end

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        rd_stb = 1'b1; port_sel = sel;
        sb_q.push_back('{exp, tag});
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(posedge clk); #1;
        wr_stb = 1'b1; port_sel = sel; wdata = d;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    // data write, then check pulse timing; returns at the negedge with new decode
    task automatic wr_data(input logic [7:0] d, input logic exp_pulse, input string tag);
        wr(1'b1, d);
        @(negedge clk);
        chk({tag, " R10 no early pulse"}, {31'h0, reconfig}, 32'd0);
        @(negedge clk);
        chk({tag, " R10 pulse"}, {31'h0, reconfig}, {31'h0, exp_pulse});
    endtask

    task automatic do_reset(input logic [STRAP_W-1:0] s);
        @(posedge clk); #1;
        rst_n = 1'b0; strap = s;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // strap 1
        do_reset(5'd1);
        chk("R10 reset no pulse", {31'h0, reconfig}, 32'd0);
        chk("R7 par_en", {31'h0, par_en}, 32'd1);
        chk("R8 par_base s1", par_base, 32'h3BC);
        chk("R8 par_irq s1", par_irq, 32'd7);
        chk("R7 uart_en s1", uart_en, 32'd3);
        chk("R9 uart0 base s1", uart_base[0], 32'h3F8);
        chk("R9 uart0 irq s1", uart_irq[0], 32'd4);
        chk("R9 uart1 base s1", uart_base[1], 32'h2F8);
        chk("R9 uart1 irq s1", uart_irq[1], 32'd3);
        chk("R7 fdc_en", {31'h0, fdc_en}, 32'd1);
        chk("R7 fdc_base lo", fdc_base, 32'h3F0);
        chk("R7 fdc_irq", fdc_irq, 32'd6);
        chk("R7 ide_en", {31'h0, ide_en}, 32'd1);
        chk("R7 ide_base lo", ide_base, 32'h1F0);
        chk("R7 ide_alt lo", ide_alt_base, 32'h3F6);
        chk("R7 ide_irq", ide_irq, 32'd14);
        rd(1'b0, 8'h88, "R2 first pointer read id");
        rd(1'b0, 8'h00, "R2 second pointer read index");
        rd(1'b1, 8'h4F, "R6 strap1 enable");
        wr(1'b0, 8'h01);
        rd(1'b1, 8'h11, "R6 strap1 address");
        rd(1'b0, 8'h01, "R1 pointer readback");

        wr_data(8'hE6, 1'b1, "E6");
        chk("R8 par_base code2", par_base, 32'h278);
        chk("R8 par_irq code2", par_irq, 32'd5);
        chk("R9 uart0 base code1", uart_base[0], 32'h2F8);
        chk("R9 uart0 irq code1", uart_irq[0], 32'd3);
        chk("R9 uart1 base code2 sel3", uart_base[1], 32'h220);
        chk("R9 uart1 irq code2", uart_irq[1], 32'd4);
        @(negedge clk);
        chk("R10 pulse one cycle", {31'h0, reconfig}, 32'd0);
        rd(1'b1, 8'hE6, "R4 address readback");

        wr_data(8'hBC, 1'b1, "BC");
        chk("R8 par_base code0", par_base, 32'h378);
        chk("R8 par_irq code0 bit3 clear", par_irq, 32'd5);
        chk("R9 uart0 base code3 sel2", uart_base[0], 32'h2E0);
        chk("R9 uart0 irq code3", uart_irq[0], 32'd3);
        chk("R9 uart1 base code3 sel2", uart_base[1], 32'h2E0);

        wr(1'b0, 8'h02);
        wr_data(8'h08, 1'b1, "pwr08");
        chk("R8 par_irq code0 bit3 set", par_irq, 32'd7);
        rd(1'b1, 8'h08, "R4 power readback");

        wr(1'b0, 8'h01);
        wr_data(8'h03, 1'b1, "03");
        chk("R8 par_base code3", par_base, 32'h000);
        chk("R8 par_irq code3", par_irq, 32'd0);
        chk("R9 uart0 base code0", uart_base[0], 32'h3F8);

        wr(1'b0, 8'h00);
        wr_data(8'hA9, 1'b1, "A9");
        chk("R7 uart_en off", uart_en, 32'd0);
        chk("R7 fdc_base hi", fdc_base, 32'h370);
        chk("R7 ide_en off", {31'h0, ide_en}, 32'd0);
        chk("R7 ide_base hi", ide_base, 32'h170);
        chk("R7 ide_alt hi", ide_alt_base, 32'h376);
        rd(1'b1, 8'hA9, "R4 enable readback");

        // out-of-range pointer
        wr(1'b0, 8'h05);
        rd(1'b0, 8'h05, "R1 pointer 5 readback");
        wr_data(8'hFF, 1'b0, "R5 ignored");
        rd(1'b1, 8'h00, "R5 bad pointer read zero");
        wr(1'b0, 8'h00);
        rd(1'b1, 8'hA9, "R5 enable untouched");
        chk("R5 fdc_base untouched", fdc_base, 32'h370);

        // lock
        wr(1'b0, 8'h02);
        wr_data(8'h48, 1'b1, "lock set");
        wr(1'b0, 8'h00);
        wr_data(8'h00, 1'b0, "R11 locked");
        rd(1'b1, 8'hA9, "R11 enable kept under lock");
        chk("R11 ide_base kept", ide_base, 32'h170);

        // strap 3, pointer write before any pointer read
        do_reset(5'd3);
        wr(1'b0, 8'h01);
        rd(1'b0, 8'h01, "R3 pointer write ends id");
        rd(1'b1, 8'h39, "R6 strap3 address");
        chk("R9 uart0 base code2 sel0", uart_base[0], 32'h3E8);
        chk("R9 uart0 irq code2", uart_irq[0], 32'd4);
        chk("R9 uart1 base code3 sel0", uart_base[1], 32'h2E8);
        chk("R9 uart1 irq code3", uart_irq[1], 32'd3);
        wr(1'b0, 8'h02);
        rd(1'b1, 8'h00, "R6 strap3 power");
        wr_data(8'h08, 1'b1, "R11 reset unlocks");
        rd(1'b1, 8'h08, "R11 write after reset lands");

        // strap 31
        do_reset(5'd31);
        rd(1'b0, 8'h88, "R2 id after reset");
        rd(1'b1, 8'h00, "R6 strap31 enable via pointer 0");
        wr(1'b0, 8'h02);
        rd(1'b1, 8'h02, "R6 strap31 power");
        chk("R6 strap31 par_en", {31'h0, par_en}, 32'd0);
        chk("R6 strap31 fdc_en", {31'h0, fdc_en}, 32'd0);
        chk("R6 strap31 uart_en", uart_en, 32'd0);

        @(negedge clk);
        chk("scoreboard drained", sb_q.size(), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule